// File: doc/BRIEF.md
# Packed FP64-to-unsigned-int32 converter

This block converts a vector of IEEE-754 double-precision lanes into unsigned 32-bit integers. Each lane produces one result, and the results are packed into the low half of a 512-bit destination. The source vector can be 128, 256 or 512 bits wide, which gives 2, 4 or 8 lanes. Alternatively, one 64-bit scalar can be broadcast to every lane when the source is marked as coming from memory.

A per-lane write mask controls which lanes are written. A masked-off lane either keeps the caller-supplied old destination value or is cleared. Rounding follows a global rounding control, unless an embedded override is selected. The override applies only to a full-width register source with the override bit set.

Values that do not fit in an unsigned 32-bit integer saturate to all-ones and raise the invalid flag. Inexact results raise the inexact flag. The unit takes one operation per cycle through a valid strobe and registers the result for one cycle.

Top module: `pd2u32_pack`

## Requirements
- R1: The `vlen` input selects the lane count: 00 gives 2 lanes, 01 gives 4 lanes, and 10 or 11 give 8 lanes. Lane j reads `src[64j+63:64j]` and writes `dst[32j+31:32j]`. Every `dst` bit at or above 32 × (lane count) reads 0.
- R2: Rounding modes use `rm` code 00 for nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. An in-range inexact value is rounded in the selected mode and raises `flag_inx`.
- R3: The mode comes from `rm_emb` only when all three hold: `vlen` is 10 or 11, `src_mem` is 0 and `bcast` is 1. In every other case it comes from `rm_glob`.
- R4: The following inputs are invalid:
    - NaN;
    - either infinity;
    - a value that rounds to 2^32 or more;
    - a negative value that rounds to a nonzero integer.

  An invalid lane returns 0xFFFFFFFF and raises `flag_inv`. That lane does not raise `flag_inx`.
- R5: A negative input that rounds to zero returns 0 and raises only `flag_inx`. Positive or negative zero returns 0 and raises no flag.
- R6: A denormal input returns 0 or 1 according to the mode and raises `flag_inx`. The one exception is a negative denormal rounded toward minus infinity, which is invalid.
- R7: Masking depends on `mask_en`:
    - With `mask_en` = 0, every lane is written.
    - With `mask_en` = 1, a lane with `wmask[j]` = 0 is handled as follows:
        - With `zero_mode` = 0, it takes `old_dst[32j+31:32j]`.
        - With `zero_mode` = 1, it is written with 0.
- R8: When `src_mem` = 1 and `bcast` = 1, every lane converts `src[63:0]`. Otherwise each lane converts its own element.
- R9: `flag_inv` and `flag_inx` are each the OR of that flag over the lanes that are both within the lane count and write-enabled. Masked-off and inactive lanes contribute nothing.
- R10: Results and flags appear on the clock edge that samples `in_valid` = 1, with `out_valid` = 1. While `in_valid` = 0, `out_valid` is 0 and `dst` and the flags hold. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| vlen | input | 2 | Vector length code |
| src_mem | input | 1 | Source is a memory operand |
| bcast | input | 1 | Broadcast bit for a memory source, override bit for a register source |
| rm_glob | input | 2 | Global rounding mode |
| rm_emb | input | 2 | Embedded rounding mode |
| mask_en | input | 1 | Write mask in use |
| zero_mode | input | 1 | 1 = zero masked lanes, 0 = merge |
| wmask | input | 8 | Per-lane write enable |
| src | input | 512 | Packed FP64 source |
| old_dst | input | 256 | Previous destination lanes used for merging |
| out_valid | output | 1 | Result strobe |
| dst | output | 512 | Packed 32-bit results |
| flag_inv | output | 1 | Invalid flag of the last operation |
| flag_inx | output | 1 | Inexact flag of the last operation |

## Verification
Some behaviour is checked by assertions on every cycle:
- the one-cycle valid latency, and the holding of results and flags in idle cycles;
- clearing of the upper destination at the shortest length;
- fully masked operations in both zero and merge form, including silent flags;
- the zero and denormal cases at each lane converter.

The arithmetic itself is shown only by the bench's sweeps. These cover rounding of halfway, near-limit and negative values in all four modes. They also cover:
- the choice between the embedded and global modes;
- broadcast against per-lane sourcing;
- all 256 write masks under both masking kinds.

// File: rtl/fcvt_pkg.sv
// Package: shared types and helpers for the packed FP64-to-u32 converter.
// Assumes vector length codes 00/01 select 2/4 lanes, all others the maximum.
package fcvt_pkg;

    typedef enum logic [1:0] {
        RM_NEAR  = 2'b00,
        RM_DOWN  = 2'b01,
        RM_UP    = 2'b10,
        RM_TRUNC = 2'b11
    } rmode_t;

    localparam logic [1:0] VLEN_128 = 2'b00;
    localparam logic [1:0] VLEN_256 = 2'b01;

    // Lane count for a length code, capped at the instance's lane count.
    function automatic int unsigned lanes_for(input logic [1:0] code, input int unsigned cap);
        int unsigned n;
        n = (code == VLEN_128) ? 2 : (code == VLEN_256) ? 4 : 8;
        return (n > cap) ? cap : n;
    endfunction

endpackage

// File: rtl/fcvt_ctl.sv
// Module: fcvt_ctl
// Operation control for the converter. It picks the rounding mode, decides
// whether lanes read the broadcast scalar, and produces per-lane active and
// write enables. Purely combinational; the inputs are assumed stable for
// the cycle in which they are sampled.
module fcvt_ctl
    import fcvt_pkg::*;
#(
    parameter int MAX_LANES = 8
) (
    input  logic [1:0]           vlen,
    input  logic                 src_mem,
    input  logic                 bcast,
    input  logic [1:0]           rm_glob,
    input  logic [1:0]           rm_emb,
    input  logic                 mask_en,
    input  logic [MAX_LANES-1:0] wmask,
    output rmode_t               rm_sel,
    output logic                 use_bcast,
    output logic [MAX_LANES-1:0] lane_on,
    output logic [MAX_LANES-1:0] lane_wr
);

    logic full_len;

    // Mode choice: the embedded override needs full length, register source, override bit.
    always_comb begin
        full_len  = !(vlen == VLEN_128 || vlen == VLEN_256);
        rm_sel    = (full_len && !src_mem && bcast) ? rmode_t'(rm_emb) : rmode_t'(rm_glob);
        use_bcast = src_mem && bcast;
    end

    // Lane enables: active within the length, written when unmasked.
    always_comb begin
        int unsigned nl;
        nl = lanes_for(vlen, MAX_LANES);
        for (int unsigned j = 0; j < MAX_LANES; j++) begin
            lane_on[j] = (j < nl);
            lane_wr[j] = (j < nl) && (!mask_en || wmask[j]);
        end
    end

endmodule

// File: rtl/fcvt_lane.sv
// Module: fcvt_lane
// Converts one binary floating-point value to an unsigned integer under one
// of four rounding modes, saturating invalid results to all-ones. It assumes
// INT_W <= MAN_W + 1, so the integer part comes from a single right shift.
// Purely combinational.
module fcvt_lane
    import fcvt_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 32
) (
    input  logic [EXP_W+MAN_W:0] fp,
    input  rmode_t               rm,
    output logic [INT_W-1:0]     res,
    output logic                 inv,
    output logic                 inx
);

    localparam int FRAC_W = MAN_W + 2;
    localparam int SH_W   = FRAC_W + INT_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(BIAS + INT_W);
    localparam logic [EXP_W-1:0] EXP_TOP = '1;
    localparam logic [EXP_W-1:0] SH_BASE = EXP_W'(BIAS + MAN_W);

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic [EXP_W-1:0] sh;
    logic [SH_W-1:0]  shifted;
    logic [INT_W-1:0] ip;
    logic             rb, sb, inc;
    logic             nan_inf, too_big, below_one;
    logic [INT_W:0]   mag;

    // Field split and alignment of the significand to a fixed binary point.
    always_comb begin
        sgn     = fp[EXP_W+MAN_W];
        ex      = fp[EXP_W+MAN_W-1:MAN_W];
        mn      = fp[MAN_W-1:0];
        sh      = SH_BASE - ex;
        shifted = SH_W'({1'b1, mn, {FRAC_W{1'b0}}} >> sh);
    end

    // Integer part, round bit and sticky bit, with small magnitudes handled apart.
    always_comb begin
        nan_inf   = (ex == EXP_TOP);
        too_big   = (ex >= EXP_LIM);
        below_one = (ex < EXP_ONE);
        if (below_one) begin
            ip = '0;
            rb = (ex == EXP_ONE - 1'b1);
            sb = rb ? (|mn) : ((|ex) || (|mn));
        end else begin
            ip = shifted[FRAC_W +: INT_W];
            rb = shifted[FRAC_W-1];
            sb = |shifted[FRAC_W-2:0];
        end
    end

    // Increment decision per mode, then the range check and saturation.
    always_comb begin
        case (rm)
            RM_NEAR:  inc = rb && (sb || ip[0]);
            RM_DOWN:  inc = sgn && (rb || sb);
            RM_UP:    inc = !sgn && (rb || sb);
            default:  inc = 1'b0;
        endcase
        mag = {1'b0, ip} + (INT_W+1)'(inc);
        inv = nan_inf || too_big || (sgn ? (mag != '0) : mag[INT_W]);
        inx = !inv && (rb || sb);
        res = inv ? '1 : mag[INT_W-1:0];
    end

    // Zero and denormal inputs must give the results and flags they are required to.
    always_comb begin
        if (ex == '0 && mn == '0) begin
            p_signed_zero_r5: assert (res == '0 && !inv && !inx);
        end
        if (ex == '0 && mn != '0) begin
            p_tiny_r6: assert (inv ? (sgn && rm == RM_DOWN) : (res <= INT_W'(1) && inx));
        end
    end

endmodule

// File: rtl/pd2u32_pack.sv
// Module: pd2u32_pack (top)
// Packed FP64 to unsigned 32-bit converter. It converts up to MAX_LANES
// lanes in parallel, applies merge or zero masking, packs the results into
// the low half of the destination, and registers results and flags for one
// cycle behind in_valid. Reset is synchronous and active low. The upper
// destination half is constant zero.
module pd2u32_pack
    import fcvt_pkg::*;
#(
    parameter int MAX_LANES = 8,
    parameter int EXP_W     = 11,
    parameter int MAN_W     = 52,
    parameter int INT_W     = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [1:0]                     vlen,
    input  logic                           src_mem,
    input  logic                           bcast,
    input  logic [1:0]                     rm_glob,
    input  logic [1:0]                     rm_emb,
    input  logic                           mask_en,
    input  logic                           zero_mode,
    input  logic [MAX_LANES-1:0]           wmask,
    input  logic [MAX_LANES*(1+EXP_W+MAN_W)-1:0] src,
    input  logic [MAX_LANES*INT_W-1:0]     old_dst,
    output logic                           out_valid,
    output logic [MAX_LANES*(1+EXP_W+MAN_W)-1:0] dst,
    output logic                           flag_inv,
    output logic                           flag_inx
);

    localparam int FP_W  = 1 + EXP_W + MAN_W;
    localparam int DST_W = MAX_LANES * FP_W;
    localparam int PK_W  = MAX_LANES * INT_W;

    rmode_t               rm_sel;
    logic                 use_bcast;
    logic [MAX_LANES-1:0] lane_on, lane_wr, inv_v, inx_v;
    logic [PK_W-1:0]      pk_nxt, pk_q;

    fcvt_ctl #(.MAX_LANES(MAX_LANES)) u_ctl (
        .vlen(vlen), .src_mem(src_mem), .bcast(bcast),
        .rm_glob(rm_glob), .rm_emb(rm_emb),
        .mask_en(mask_en), .wmask(wmask),
        .rm_sel(rm_sel), .use_bcast(use_bcast),
        .lane_on(lane_on), .lane_wr(lane_wr)
    );

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        logic [FP_W-1:0]  elt;
        logic [INT_W-1:0] res;
        logic             inv, inx;

        // Source pick: the broadcast scalar or the lane's own element.
        assign elt = use_bcast ? src[FP_W-1:0] : src[g*FP_W +: FP_W];

        fcvt_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_lane (
            .fp(elt), .rm(rm_sel), .res(res), .inv(inv), .inx(inx)
        );

        // Lane result after masking; inactive lanes are cleared.
        assign pk_nxt[g*INT_W +: INT_W] = lane_wr[g] ? res :
            ((lane_on[g] && !zero_mode) ? old_dst[g*INT_W +: INT_W] : '0);
        assign inv_v[g] = lane_wr[g] && inv;
        assign inx_v[g] = lane_wr[g] && inx;
    end

    // Result register: capture on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pk_q      <= '0;
            flag_inv  <= 1'b0;
            flag_inx  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                pk_q     <= pk_nxt;
                flag_inv <= |inv_v;
                flag_inx <= |inx_v;
            end
        end
    end

    assign dst = {{(DST_W-PK_W){1'b0}}, pk_q};

    p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dst) && $stable(flag_inv) && $stable(flag_inx)));
    p_short_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen == VLEN_128) |=> (dst[DST_W-1:2*INT_W] == '0));
    p_zero_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && zero_mode && wmask == '0) |=> (dst == '0));
    p_merge_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && !zero_mode && wmask == '0 && vlen[1])
        |=> (dst[PK_W-1:0] == $past(old_dst)));
    p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && wmask == '0) |=> (!flag_inv && !flag_inx));

endmodule

// File: tb/pd2u32_pack_bench.sv
`timescale 1ns/1ps
module pd2u32_pack_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   vlen = 2'b10;
    logic         src_mem = 1'b0;
    logic         bcast = 1'b0;
    logic [1:0]   rm_glob = 2'b00;
    logic [1:0]   rm_emb = 2'b00;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic [7:0]   wmask = 8'h00;
    logic [511:0] src = '0;
    logic [255:0] old_dst = '0;
    logic         out_valid;
    logic [511:0] dst;
    logic         flag_inv, flag_inx;

    logic [511:0] exp_dst;
    logic         exp_inv, exp_inx;
    int           n_vec = 0;
    int           n_bad = 0;
    bit           done = 0;

    pd2u32_pack u_pd2u32_pack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen(vlen),
        .src_mem(src_mem), .bcast(bcast), .rm_glob(rm_glob), .rm_emb(rm_emb),
        .mask_en(mask_en), .zero_mode(zero_mode), .wmask(wmask),
        .src(src), .old_dst(old_dst), .out_valid(out_valid), .dst(dst),
        .flag_inv(flag_inv), .flag_inx(flag_inx)
    );

    always #5 clk = ~clk;

    localparam int NPOOL = 28;

    function automatic logic [63:0] pool(input int i);
        case (i)
            0:  return $realtobits(0.0);
            1:  return 64'h8000_0000_0000_0000;
            2:  return $realtobits(0.5);
            3:  return $realtobits(1.5);
            4:  return $realtobits(2.5);
            5:  return $realtobits(-0.4);
            6:  return $realtobits(-0.5);
            7:  return $realtobits(-0.6);
            8:  return $realtobits(-1.0);
            9:  return $realtobits(4294967295.0);
            10: return $realtobits(4294967295.4);
            11: return $realtobits(4294967295.5);
            12: return $realtobits(4294967296.0);
            13: return $realtobits(1.0e300);
            14: return 64'h7FF0_0000_0000_0000;
            15: return 64'hFFF0_0000_0000_0000;
            16: return 64'h7FF8_0000_0000_0001;
            17: return 64'h0000_0000_0000_0001;
            18: return 64'h800F_FFFF_FFFF_FFFF;
            19: return $realtobits(123456.789);
            20: return $realtobits(3.0);
            21: return $realtobits(0.49999999999999994);
            22: return $realtobits(2147483648.5);
            23: return $realtobits(1.0e-5);
            24: return $realtobits(65535.75);
            25: return $realtobits(-1.0e-300);
            26: return $realtobits(0.75);
            default: return $realtobits(7.5);
        endcase
    endfunction

    // Arithmetic model of one lane, from the requirements R2, R4, R5, R6.
    task automatic ref_lane(input logic [63:0] b, input logic [1:0] rm,
                            output logic [31:0] r, output bit iv, output bit ix);
        real x, q, f, d;
        if (b[62:52] == 11'h7FF) begin
            r = 32'hFFFF_FFFF; iv = 1; ix = 0;
            return;
        end
        x = $bitstoreal(b);
        case (rm)
            2'b00: begin
                f = $floor(x);
                d = x - f;
                if (d > 0.5) q = f + 1.0;
                else if (d < 0.5) q = f;
                else q = (f / 2.0 == $floor(f / 2.0)) ? f : f + 1.0;
            end
            2'b01: q = $floor(x);
            2'b10: q = $ceil(x);
            default: q = (x < 0.0) ? $ceil(x) : $floor(x);
        endcase
        if (q < 0.0 || q > 4294967295.0) begin
            r = 32'hFFFF_FFFF; iv = 1; ix = 0;
        end else begin
            r = 32'(longint'(q)); iv = 0; ix = (q != x);
        end
    endtask

    // Whole-operation model from R1, R3, R7, R8, R9.
    task automatic ref_op();
        int nl;
        logic [1:0] rm;
        logic [63:0] e;
        logic [31:0] r;
        bit iv, ix;
        nl = (vlen == 2'b00) ? 2 : (vlen == 2'b01) ? 4 : 8;
        rm = (vlen[1] && !src_mem && bcast) ? rm_emb : rm_glob;
        exp_dst = '0; exp_inv = 0; exp_inx = 0;
        for (int j = 0; j < nl; j++) begin
            e = (src_mem && bcast) ? src[63:0] : src[64*j +: 64];
            if (!mask_en || wmask[j]) begin
                ref_lane(e, rm, r, iv, ix);
                exp_dst[32*j +: 32] = r;
                exp_inv = exp_inv | iv;
                exp_inx = exp_inx | ix;
            end else if (!zero_mode) begin
                exp_dst[32*j +: 32] = old_dst[32*j +: 32];
            end
        end
    endtask

    task automatic check(input string tag);
        n_vec++;
        if (dst !== exp_dst || flag_inv !== exp_inv || flag_inx !== exp_inx || out_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL %s: dst=%h inv=%b inx=%b vld=%b expected dst=%h inv=%b inx=%b vld=1",
                     tag, dst, flag_inv, flag_inx, out_valid, exp_dst, exp_inv, exp_inx);
        end
    endtask

    task automatic check_idle(input string tag);
        n_vec++;
        if (dst !== exp_dst || flag_inv !== exp_inv || flag_inx !== exp_inx || out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL %s idle: dst=%h inv=%b inx=%b vld=%b expected dst=%h inv=%b inx=%b vld=0",
                     tag, dst, flag_inv, flag_inx, out_valid, exp_dst, exp_inv, exp_inx);
        end
    endtask

    task automatic go(input string tag);
        ref_op();
        in_valid = 1'b1;
        @(negedge clk);
        check(tag);
    endtask

    task automatic fill(input int base, input int step);
        for (int j = 0; j < 8; j++) src[64*j +: 64] = pool((base + j * step) % NPOOL);
    endtask

    initial begin
        logic [31:0] r;
        bit iv, ix;
        string tag;

        repeat (3) @(negedge clk);
        // R10: reset state
        n_vec++;
        if (dst !== '0 || flag_inv !== 0 || flag_inx !== 0 || out_valid !== 0) begin
            n_bad++;
            $display("FAIL R10 reset: dst=%h inv=%b inx=%b vld=%b expected all 0",
                     dst, flag_inv, flag_inx, out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5 R6: scalar sweep through broadcast, other lanes hold unrelated values
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < NPOOL; i++) begin
                vlen = 2'b10; src_mem = 1; bcast = 1; mask_en = 0;
                rm_glob = 2'(m); rm_emb = ~2'(m);
                fill(i + 5, 3);
                src[63:0] = pool(i);
                ref_lane(pool(i), 2'(m), r, iv, ix);
                if (iv) tag = "R4";
                else if (pool(i)[62:52] == 11'd0 && pool(i)[51:0] != 52'd0) tag = "R6";
                else if (pool(i)[63] || pool(i)[62:0] == 63'd0) tag = "R5";
                else tag = "R2";
                go(tag);
            end
        end

        // R8: broadcast against per-lane sourcing
        for (int i = 0; i < NPOOL; i++) begin
            fill(i, 1);
            vlen = 2'b10; rm_glob = 2'(i); rm_emb = 2'b11; mask_en = 0;
            src_mem = 1; bcast = 1; go("R8");
            src_mem = 1; bcast = 0; go("R8");
            src_mem = 0; bcast = 1; vlen = 2'b01; go("R8");
        end

        // R1: every length code with distinct lanes
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < NPOOL; i++) begin
                vlen = 2'(v); src_mem = 0; bcast = 0; mask_en = 0;
                rm_glob = 2'(i); fill(i, 3);
                old_dst = {8{32'hDEAD_0000 | 32'(i)}};
                go("R1");
            end
        end

        // R3: rounding source selection over length, source kind and override bit
        for (int v = 0; v < 4; v++)
            for (int sm = 0; sm < 2; sm++)
                for (int b = 0; b < 2; b++)
                    for (int p = 0; p < 4; p++) begin
                        vlen = 2'(v); src_mem = sm[0]; bcast = b[0]; mask_en = 0;
                        case (p)
                            0: begin rm_glob = 2'b00; rm_emb = 2'b10; end
                            1: begin rm_glob = 2'b10; rm_emb = 2'b00; end
                            2: begin rm_glob = 2'b01; rm_emb = 2'b10; end
                            default: begin rm_glob = 2'b11; rm_emb = 2'b10; end
                        endcase
                        for (int j = 0; j < 8; j++)
                            src[64*j +: 64] = (j % 2 == 0) ? $realtobits(2.5) : $realtobits(1.25);
                        go("R3");
                    end

        // R7: all write masks in merge and zero form, plus masks ignored when disabled
        for (int z = 0; z < 2; z++)
            for (int m = 0; m < 256; m++) begin
                vlen = 2'b10; src_mem = 0; bcast = 0; mask_en = 1; zero_mode = z[0];
                wmask = 8'(m); rm_glob = 2'(m); fill(m, 7);
                for (int j = 0; j < 8; j++) old_dst[32*j +: 32] = 32'hA500_0000 | (32'(m) << 8) | 32'(j);
                go("R7");
            end
        for (int i = 0; i < NPOOL; i++) begin
            mask_en = 0; zero_mode = i[0]; wmask = 8'(i * 37); fill(i, 5);
            vlen = 2'(i); go("R7");
        end

        // R9: flags from masked-off and inactive lanes must not show
        for (int k = 0; k < 8; k++) begin
            vlen = 2'b10; mask_en = 1; zero_mode = k[0]; wmask = ~(8'd1 << k);
            for (int j = 0; j < 8; j++) src[64*j +: 64] = $realtobits(3.0);
            src[64*k +: 64] = (k % 2 == 0) ? pool(16) : $realtobits(1.5);
            rm_glob = 2'b00;
            go("R9");
        end
        vlen = 2'b00; mask_en = 0;
        for (int j = 0; j < 8; j++) src[64*j +: 64] = (j < 2) ? $realtobits(3.0) : pool(16);
        go("R9");
        src[127:64] = $realtobits(0.75);
        go("R9");
        src[63:0] = pool(14);
        go("R9");

        // R10: results hold while idle
        vlen = 2'b10; fill(3, 1); rm_glob = 2'b10;
        go("R10");
        in_valid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            fill(c + 9, 2);
            wmask = 8'(c);
            @(negedge clk);
            check_idle("R10");
        end
        fill(20, 1);
        go("R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule